// File: doc/BRIEF.md
# Command Transfer Latency Monitor

This block sits beside a command path and checks delivery deadlines. Commands enter the path through a send handshake and leave it through a receive handshake. Both handshakes use valid/ready, carry a 32-bit command and name one of three sources: core (code 0), software (code 1) and IP (code 2). The monitor drives no part of the path. It only watches the handshakes and raises per-source error pulses.

Each accepted send is stored with a stamp taken from a free-running cycle counter. Each source has its own in-order tracking queue. The oldest pending command of a source must reach the receive side within a fixed window, set by default to 16 cycles after its own send cycle. If it does not, a timeout pulse is raised and the entry is discarded. The monitor also flags three other faults: a received value that differs from the one expected, a receive with nothing pending, and a send that arrives while the tracking queue of its source is full.

Every error output is a 3-bit vector indexed by source code. Each bit is a registered one-cycle pulse. It is high in the cycle after the clock edge at which the event is sampled.

Top module: `cmd_latency_monitor`

## Requirements
- R1: A send counts only on an edge where snd_valid and snd_ready are both high and snd_src is 0, 1 or 2. A receive counts only on an edge where rcv_valid and rcv_ready are both high and rcv_src is 0, 1 or 2. Any other combination, including source code 3, changes nothing.
- R2: A command received up to and including 16 edges after the edge on which it was sent raises no timeout.
- R3: If the oldest pending command of a source is still pending 17 edges after its send edge, err_timeout[src] is high for exactly the following cycle and that entry is removed.
- R4: Every pending command is timed from its own send edge. The three sources are tracked and reported independently.
- R5: Commands of a source are matched in send order. A receive whose value differs from the oldest pending command of its source raises err_mismatch[src] and still consumes that entry.
- R6: A receive for a source with nothing pending raises err_orphan[src]. A send on the same edge does not count as pending for that receive.
- R7: Each source tracks up to 16 pending commands. A send while 16 are pending raises err_overflow[src] and is not stored, even if an entry leaves on the same edge.
- R8: A receive on the edge where the oldest entry expires consumes that entry. It raises only the timeout, with no mismatch compare.
- R9: A synchronous active-high reset empties all queues and restarts the cycle counter. All error outputs are low while reset is asserted and in the cycle after. Commands pending at reset never time out.
- R10: Deadlines stay exact when the 16-bit cycle counter wraps from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | 1 | Send side valid |
| snd_ready | input | 1 | Send side ready |
| snd_src | input | 2 | Send source code (0 core, 1 software, 2 IP) |
| snd_cmd | input | 32 | Sent command value |
| rcv_valid | input | 1 | Receive side valid |
| rcv_ready | input | 1 | Receive side ready |
| rcv_src | input | 2 | Receive source code |
| rcv_cmd | input | 32 | Received command value |
| err_timeout | output | 3 | Deadline missed, one bit per source |
| err_mismatch | output | 3 | Received value differs from expected, per source |
| err_orphan | output | 3 | Receive with nothing pending, per source |
| err_overflow | output | 3 | Send dropped because tracking was full, per source |

## Verification
The bench probes both edges of the deadline. A receive at age 16 is tested, where an off-by-one design would raise a false timeout. A receive at age 17 is tested, where a design that let the receive win would report a mismatch or miss the timeout. Back-to-back sends that expire on consecutive edges catch a design that times every entry from the first send, or that only notices the next head one cycle late. Filling a queue to 16 and then sending once more shows whether the rejected command was stored anyway, which would produce a seventeenth timeout. A run across the counter wrap catches unsigned age arithmetic that breaks at 65535, and a reset with commands in flight catches stale entries that outlive reset.

// File: rtl/cmd_mon_pkg.sv
package cmd_mon_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_CORE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_IP   = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef struct packed {
    logic timeout;
    logic mismatch;
    logic orphan;
    logic overflow;
  } lane_err_t;
endpackage

// File: rtl/cmd_mon_timebase.sv
module cmd_mon_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  // R10: the stamp source advances by one each cycle, wrapping modulo 2^TS_W
  p_now_advance_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> now == TS_W'($past(now) + 1'b1));
endmodule

// File: rtl/cmd_mon_fifo.sv
module cmd_mon_fifo #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  // storage has no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the lane never writes into a full queue
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  // R6: the lane never pops an empty queue
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
  // R7: occupancy stays within the configured depth
  p_count_limit_r7: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/cmd_mon_lane.sv
module cmd_mon_lane
  import cmd_mon_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 16,
  parameter int WINDOW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now,
  input  logic             push_req,
  input  logic [CMD_W-1:0] push_cmd,
  input  logic             rcv_req,
  input  logic [CMD_W-1:0] rcv_cmd,
  output lane_err_t        err
);
  localparam int ENT_W = CMD_W + TS_W;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [ENT_W-1:0] head;
  logic [CMD_W-1:0] head_cmd;
  logic [TS_W-1:0]  head_ts;
  logic [TS_W-1:0]  age;
  logic             empty;
  logic             full;
  logic [CNT_W-1:0] count;
  logic             expired;
  logic             pop;
  logic             push_ok;
  lane_err_t        err_d;

  cmd_mon_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_track (
    .clk   (clk),
    .rst   (rst),
    .push  (push_ok),
    .wdata ({push_cmd, now}),
    .pop   (pop),
    .rdata (head),
    .empty (empty),
    .full  (full),
    .count (count)
  );

  assign head_cmd = head[ENT_W-1:TS_W];
  assign head_ts  = head[TS_W-1:0];
  assign age      = now - head_ts;             // modulo arithmetic survives wrap
  assign expired  = !empty && (age > TS_W'(WINDOW));
  assign pop      = !empty && (expired || rcv_req);
  assign push_ok  = push_req && !full;

  always_comb begin
    err_d          = '0;
    err_d.timeout  = expired;
    err_d.mismatch = rcv_req && !empty && !expired && (rcv_cmd != head_cmd);
    err_d.orphan   = rcv_req && empty;
    err_d.overflow = push_req && full;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= '0;
    else     err <= err_d;
  end

  // R3: a pending head never grows older than one cycle past the window
  p_head_age_r3: assert property (@(posedge clk) disable iff (rst)
    !empty |-> age <= TS_W'(WINDOW + 1));
  // R3: an expiring entry leaves the queue
  p_expire_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (expired && !push_ok) |=> count == $past(count) - 1'b1);
  // R6: a receive on an empty queue is reported next cycle
  p_orphan_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rcv_req && empty) |=> err.orphan);
  // R7: a rejected send leaves a full queue full when nothing left
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !pop) |=> full);
  // R8: a late receive never produces a mismatch together with the timeout
  p_late_single_r8: assert property (@(posedge clk) disable iff (rst)
    err.timeout |-> !err.mismatch && !err.orphan);
endmodule

// File: rtl/cmd_latency_monitor.sv
module cmd_latency_monitor
  import cmd_mon_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 16,
  parameter int WINDOW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snd_valid,
  input  logic               snd_ready,
  input  logic [SRC_W-1:0]   snd_src,
  input  logic [CMD_W-1:0]   snd_cmd,
  input  logic               rcv_valid,
  input  logic               rcv_ready,
  input  logic [SRC_W-1:0]   rcv_src,
  input  logic [CMD_W-1:0]   rcv_cmd,
  output logic [NUM_SRC-1:0] err_timeout,
  output logic [NUM_SRC-1:0] err_mismatch,
  output logic [NUM_SRC-1:0] err_orphan,
  output logic [NUM_SRC-1:0] err_overflow
);
  logic [TS_W-1:0]    now;
  logic               snd_fire;
  logic               rcv_fire;
  logic [NUM_SRC-1:0] push_vec;
  logic [NUM_SRC-1:0] rcv_vec;

  assign snd_fire = snd_valid && snd_ready;
  assign rcv_fire = rcv_valid && rcv_ready;

  cmd_mon_timebase #(.TS_W(TS_W)) u_time (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
    lane_err_t lane_err;

    assign push_vec[s] = snd_fire && (snd_src == SRC_W'(s));
    assign rcv_vec[s]  = rcv_fire && (rcv_src == SRC_W'(s));

    cmd_mon_lane #(
      .CMD_W  (CMD_W),
      .TS_W   (TS_W),
      .DEPTH  (DEPTH),
      .WINDOW (WINDOW)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .now      (now),
      .push_req (push_vec[s]),
      .push_cmd (snd_cmd),
      .rcv_req  (rcv_vec[s]),
      .rcv_cmd  (rcv_cmd),
      .err      (lane_err)
    );

    assign err_timeout[s]  = lane_err.timeout;
    assign err_mismatch[s] = lane_err.mismatch;
    assign err_orphan[s]   = lane_err.orphan;
    assign err_overflow[s] = lane_err.overflow;
  end

  // R1: a handshake reaches at most one source lane
  p_one_lane_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_vec) && $onehot0(rcv_vec));
  // R1: an incomplete send handshake cannot cause an overflow
  p_idle_send_r1: assert property (@(posedge clk) disable iff (rst)
    !snd_fire |=> err_overflow == '0);
  // R9: outputs are quiet in the cycle after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (err_timeout | err_mismatch | err_orphan | err_overflow) == '0);
endmodule

// File: tb/cmd_latency_monitor_tb.sv
`timescale 1ns/1ps
module cmd_latency_monitor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snd_valid = 0, snd_ready = 0, rcv_valid = 0, rcv_ready = 0;
  logic [1:0]  snd_src = 0, rcv_src = 0;
  logic [31:0] snd_cmd = 0, rcv_cmd = 0;
  logic [2:0]  err_timeout, err_mismatch, err_orphan, err_overflow;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 0;
  bit done   = 0;

  // reference model state
  logic [65:0] mq[$];             // {src, send cycle, command}
  int          mcyc = 0;
  logic [2:0]  x_to = 0, x_mm = 0, x_or = 0, x_ov = 0;
  int          obs_to[3], obs_mm[3], obs_or[3], obs_ov[3];
  int          b_to[3], b_mm[3], b_or[3], b_ov[3];

  always #2.5 clk = ~clk;

  cmd_latency_monitor u_dut (
    .clk(clk), .rst(rst),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_src(snd_src), .snd_cmd(snd_cmd),
    .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_src(rcv_src), .rcv_cmd(rcv_cmd),
    .err_timeout(err_timeout), .err_mismatch(err_mismatch),
    .err_orphan(err_orphan), .err_overflow(err_overflow)
  );

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      x_to = 0; x_mm = 0; x_or = 0; x_ov = 0;
      mcyc = 0;
    end else begin
      for (int s = 0; s < 3; s++) begin
        int idx; int n; bit rs; bit ss;
        idx = -1; n = 0;
        foreach (mq[i]) if (mq[i][65:64] == 2'(s)) begin
          if (idx < 0) idx = i;
          n++;
        end
        rs = rcv_valid && rcv_ready && (rcv_src == 2'(s));
        ss = snd_valid && snd_ready && (snd_src == 2'(s));
        x_to[s] = 0; x_mm[s] = 0; x_or[s] = 0; x_ov[s] = 0;
        if (idx >= 0 && (mcyc - int'(mq[idx][63:32])) > 16) begin
          x_to[s] = 1;
          mq.delete(idx);
        end else if (rs) begin
          if (idx < 0) x_or[s] = 1;
          else begin
            if (mq[idx][31:0] != rcv_cmd) x_mm[s] = 1;
            mq.delete(idx);
          end
        end
        if (ss) begin
          if (n == 16) x_ov[s] = 1;
          else mq.push_back({2'(s), 32'(mcyc), snd_cmd});
        end
      end
      mcyc++;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks += 4;
      if (err_timeout !== x_to) begin
        fails++; $display("FAIL R3 timeout vector actual=%b expected=%b cyc=%0d", err_timeout, x_to, mcyc);
      end
      if (err_mismatch !== x_mm) begin
        fails++; $display("FAIL R5 mismatch vector actual=%b expected=%b cyc=%0d", err_mismatch, x_mm, mcyc);
      end
      if (err_orphan !== x_or) begin
        fails++; $display("FAIL R6 orphan vector actual=%b expected=%b cyc=%0d", err_orphan, x_or, mcyc);
      end
      if (err_overflow !== x_ov) begin
        fails++; $display("FAIL R7 overflow vector actual=%b expected=%b cyc=%0d", err_overflow, x_ov, mcyc);
      end
      for (int s = 0; s < 3; s++) begin
        obs_to[s] += int'(err_timeout[s]);
        obs_mm[s] += int'(err_mismatch[s]);
        obs_or[s] += int'(err_orphan[s]);
        obs_ov[s] += int'(err_overflow[s]);
      end
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit sv, bit sr, logic [1:0] ss, logic [31:0] sc,
                      bit rv, bit rr, logic [1:0] rs, logic [31:0] rc);
    snd_valid = sv; snd_ready = sr; snd_src = ss; snd_cmd = sc;
    rcv_valid = rv; rcv_ready = rr; rcv_src = rs; rcv_cmd = rc;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic send(logic [1:0] s, logic [31:0] c);
    step(1, 1, s, c, 0, 0, 0, 0);
  endtask

  task automatic recv(logic [1:0] s, logic [31:0] c);
    step(0, 0, 0, 0, 1, 1, s, c);
  endtask

  task automatic snap();
    for (int s = 0; s < 3; s++) begin
      b_to[s] = obs_to[s]; b_mm[s] = obs_mm[s]; b_or[s] = obs_or[s]; b_ov[s] = obs_ov[s];
    end
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_on = 1;
    @(negedge clk);
    // R9: all outputs low while reset is held
    check_eq("R9 reset outputs", int'({err_timeout, err_mismatch, err_orphan, err_overflow}), 0);
    rst = 0;
    idle(2);

    // R2: receive exactly 16 edges after the send
    snap();
    send(0, 32'hA5A5_0001); idle(15); recv(0, 32'hA5A5_0001); idle(3);
    check_eq("R2 on-time core timeouts", obs_to[0] - b_to[0], 0);
    check_eq("R2 on-time core mismatches", obs_mm[0] - b_mm[0], 0);

    // R3: never received
    snap();
    send(1, 32'h0000_BEEF); idle(22);
    check_eq("R3 lost sw command timeouts", obs_to[1] - b_to[1], 1);

    // R8: receive on the expiry edge
    snap();
    send(2, 32'h1234_5678); idle(16); recv(2, 32'h1234_5678); idle(3);
    check_eq("R8 late ip timeouts", obs_to[2] - b_to[2], 1);
    check_eq("R8 late ip mismatches", obs_mm[2] - b_mm[2], 0);
    check_eq("R8 late ip orphans", obs_or[2] - b_or[2], 0);

    // R4: several outstanding, each with its own deadline, sources independent
    snap();
    send(0, 32'h10); send(0, 32'h11); send(0, 32'h12); send(1, 32'h20);
    recv(0, 32'h10); idle(10); recv(1, 32'h20); idle(20);
    check_eq("R4 core timeouts of two unreceived", obs_to[0] - b_to[0], 2);
    check_eq("R4 sw on-time timeouts", obs_to[1] - b_to[1], 0);

    // R5: in-order matching and value compare
    snap();
    send(0, 32'hCAFE_0001); send(0, 32'hCAFE_0002);
    recv(0, 32'hDEAD_0000); recv(0, 32'hCAFE_0002); idle(20);
    check_eq("R5 core mismatches", obs_mm[0] - b_mm[0], 1);
    check_eq("R5 core timeouts after consume", obs_to[0] - b_to[0], 0);

    // R6: receive with nothing pending, including same-edge send
    snap();
    recv(1, 32'h55); step(1, 1, 1, 32'h66, 1, 1, 1, 32'h66); idle(2); recv(1, 32'h66); idle(3);
    check_eq("R6 sw orphans", obs_or[1] - b_or[1], 2);
    check_eq("R6 sw mismatches", obs_mm[1] - b_mm[1], 0);

    // R7: seventeenth pending send is rejected and not stored
    snap();
    for (int i = 0; i < 16; i++) send(2, 32'(32'h300 + i));
    send(2, 32'h3FF); idle(22);
    check_eq("R7 ip overflows", obs_ov[2] - b_ov[2], 1);
    check_eq("R7 ip timeouts of stored entries", obs_to[2] - b_to[2], 16);

    // R1: incomplete handshakes and source code 3 are ignored
    snap();
    step(1, 0, 0, 32'h1, 0, 0, 0, 0); step(0, 1, 1, 32'h2, 0, 0, 0, 0);
    step(1, 1, 3, 32'h3, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 2, 32'h4);
    step(0, 0, 0, 0, 0, 1, 0, 32'h5); step(0, 0, 0, 0, 1, 1, 3, 32'h6);
    idle(22);
    check_eq("R1 ignored handshake timeouts", (obs_to[0]+obs_to[1]+obs_to[2]) - (b_to[0]+b_to[1]+b_to[2]), 0);
    check_eq("R1 ignored handshake orphans", (obs_or[0]+obs_or[1]+obs_or[2]) - (b_or[0]+b_or[1]+b_or[2]), 0);

    // R9: reset with commands in flight
    snap();
    send(0, 32'h77); send(1, 32'h88);
    rst = 1; idle(2); rst = 0; idle(22);
    check_eq("R9 timeouts after reset", (obs_to[0]+obs_to[1]) - (b_to[0]+b_to[1]), 0);

    // R10: deadlines across the counter wrap
    while (mcyc < 65520) idle(1);
    snap();
    for (int k = 0; k < 4; k++) begin
      send(1, 32'(32'h900 + k)); idle(15); recv(1, 32'(32'h900 + k));
    end
    send(0, 32'hABCD); idle(22);
    check_eq("R10 on-time across wrap timeouts", obs_to[1] - b_to[1], 0);
    check_eq("R10 late across wrap timeouts", obs_to[0] - b_to[0], 1);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule